// File: doc/BRIEF.md
# Conversion Result Queue with Status Flags

This block buffers completed analog-to-digital conversion results on their way to a processor read port. Each time the conversion engine finishes, it presents a 10-bit sample, a 5-bit channel index and a 1-bit start-priority tag for one cycle. The block stores them in a four-entry first-in first-out queue. It reports whether the queue is empty or full, and it latches an overflow indication when a result arrives with no room left. Results that arrive while the queue is full are discarded and never replace stored data.

Software reads a 16-bit data word. One mode bit selects the layout of that word: either sample, tag and channel packed together, or the sample alone aligned to bit 0. The word can be fetched one byte at a time, and only an access to the upper byte removes the entry from the queue. A programmable stage count raises a sticky interrupt flag once enough results have been stored. A single-cycle clear command discards the whole queue.

Top module: `adc_result_fifo`

## Requirements
- R1: After reset, empty_o is 1, full_o, ovf_o, irq_flag_o and irq_o are 0, and rd_data_o is 16'h0000.
- R2: A write accepted into an empty queue drives empty_o to 0 after the clock edge that stores it.
- R3: full_o is 1 exactly when 4 entries are stored. Entries are read back in the order they were written.
- R4: A write while full_o is 1 is discarded: stored entries and the count are unchanged, and ovf_o becomes 1.
- R5: A one-cycle pulse on clr_i empties the queue (empty_o=1, full_o=0) and takes priority over a write or pop in the same cycle.
- R6: With stage count thresh_i=N (2 bits), irq_flag_o is set by the write that makes the stored count equal to N+1, and by no other write.
- R7: irq_o is 1 only while both irq_flag_o and irq_en_i are 1.
- R8: rd_hi_i pops the head entry when the queue is not empty; a read with only rd_lo_i returns the same head word and does not pop. A 16-bit read asserts both strobes.
- R9: With layout_i=0 the read word is {sample[9:0], tag, channel[4:0]}: sample in bits 15:6, tag in bit 5, channel in bits 4:0.
- R10: With layout_i=1 the read word is {6'b0, sample[9:0]}.
- R11: ovf_o and irq_flag_o are sticky. ovf_o clears on ovf_clr_i or clr_i, and irq_flag_o clears on irq_clr_i. A set in the same cycle wins over a clear.
- R12: A read while empty leaves rd_data_o at its previous value and the queue empty. A write and a pop in the same cycle are both applied.
- R13: rd_data_o is captured on the clock edge of the read strobe and holds until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Conversion complete, write one entry |
| wr_result_i | input | 10 | Conversion sample |
| wr_tag_i | input | 1 | Start-priority tag |
| wr_chan_i | input | 5 | Channel index |
| rd_lo_i | input | 1 | Read strobe for bits 7:0 (no pop) |
| rd_hi_i | input | 1 | Read strobe for bits 15:8 (pops) |
| clr_i | input | 1 | Clear command, empties the queue and overflow |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| irq_clr_i | input | 1 | Clear the interrupt flag |
| thresh_i | input | 2 | Stage count N; the flag sets at N+1 entries |
| irq_en_i | input | 1 | Interrupt enable |
| layout_i | input | 1 | Read word layout: 0 packed, 1 right-justified |
| rd_data_o | output | 16 | Read data word |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue full |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_flag_o | output | 1 | Sticky stage-count interrupt flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that the count stays within the depth and that a write while full leaves the queue full. They also check that a clear leaves the queue empty, that a pop while empty changes nothing, that the overflow and interrupt flags rise only after a write attempt, and that the right-justified layout zeroes the upper bits. Only the bench's scenarios show the data itself: the read order, that stored entries survive an overflowing write, the packed bit positions, and that a low-byte read does not pop. The same holds for the exact write that reaches each stage count and for a write and pop in the same cycle.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
  localparam int RES_W  = 10;
  localparam int CHAN_W = 5;
  localparam int WORD_W = RES_W + 1 + CHAN_W;

  typedef struct packed {
    logic [RES_W-1:0]  res;
    logic              tag;
    logic [CHAN_W-1:0] chan;
  } entry_t;
endpackage

// File: rtl/adc_fifo_store.sv
module adc_fifo_store
  import adc_fifo_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH)
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      push_i,
  input  logic      pop_i,
  input  entry_t    entry_i,
  output entry_t    head_o,
  output logic [CW:0] count_o
);
  logic [CW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW:0]   count_q;
  entry_t        slot_q [DEPTH];

  function automatic logic [CW-1:0] ptr_inc(input logic [CW-1:0] p);
    return (p == CW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    slot_q[g] <= '0;
      else if (push_i && !clr_i && wr_ptr_q == CW'(g)) slot_q[g] <= entry_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_o  = slot_q[rd_ptr_q];
  assign count_o = count_q;

  // R3
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= (CW+1)'(DEPTH));

  // R5
  clr_resets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_q == '0 && rd_ptr_q == wr_ptr_q));
endmodule

// File: rtl/adc_fifo_status.sv
module adc_fifo_status #(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          drop_i,
  input  logic [CW:0]   count_i,
  input  logic [CW-1:0] thresh_i,
  input  logic          ovf_clr_i,
  input  logic          irq_clr_i,
  output logic          ovf_o,
  output logic          irq_flag_o
);
  logic        ovf_q, irq_q;
  logic [CW:0] count_after;
  logic        hit;

  always_comb begin
    count_after = count_i + (CW+1)'(push_i) - (CW+1)'(pop_i);
    hit         = push_i && (count_after == ({1'b0, thresh_i} + 1'b1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (drop_i)                    ovf_q <= 1'b1;
      else if (ovf_clr_i || clr_i)   ovf_q <= 1'b0;
      if (hit)                       irq_q <= 1'b1;
      else if (irq_clr_i)            irq_q <= 1'b0;
    end
  end

  assign ovf_o      = ovf_q;
  assign irq_flag_o = irq_q;

  // R4
  ovf_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |-> $past(drop_i));

  // R6
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(push_i));

  // R11
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !ovf_clr_i && !clr_i) |=> ovf_q);
endmodule

// File: rtl/adc_fifo_rdport.sv
module adc_fifo_rdport
  import adc_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic              valid_i,
  input  logic              layout_i,
  input  entry_t            head_i,
  output logic [WORD_W-1:0] data_o
);
  logic [WORD_W-1:0] word_d, data_q;

  always_comb begin
    if (layout_i) word_d = {{(WORD_W-RES_W){1'b0}}, head_i.res};
    else          word_d = {head_i.res, head_i.tag, head_i.chan};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  data_q <= '0;
    else if (strobe_i && valid_i) data_q <= word_d;
  end

  assign data_o = data_q;

  // R10
  right_just_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && valid_i && layout_i) |=> (data_q[WORD_W-1:RES_W] == '0));

  // R12
  empty_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !valid_i) |=> $stable(data_q));
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo
  import adc_fifo_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int CW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [RES_W-1:0]  wr_result_i,
  input  logic              wr_tag_i,
  input  logic [CHAN_W-1:0] wr_chan_i,
  input  logic              rd_lo_i,
  input  logic              rd_hi_i,
  input  logic              clr_i,
  input  logic              ovf_clr_i,
  input  logic              irq_clr_i,
  input  logic [CW-1:0]     thresh_i,
  input  logic              irq_en_i,
  input  logic              layout_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              irq_flag_o,
  output logic              irq_o
);
  logic [CW:0] count;
  entry_t      head, wr_entry;
  logic        push, pop, drop;

  assign wr_entry = '{res: wr_result_i, tag: wr_tag_i, chan: wr_chan_i};
  assign empty_o  = (count == '0);
  assign full_o   = (count == (CW+1)'(DEPTH));
  assign push     = wr_valid_i && !full_o && !clr_i;
  assign drop     = wr_valid_i &&  full_o && !clr_i;
  assign pop      = rd_hi_i && !empty_o && !clr_i;

  adc_fifo_store #(.DEPTH(DEPTH)) u_store (
    .clk_i, .rst_ni, .clr_i,
    .push_i (push),
    .pop_i  (pop),
    .entry_i(wr_entry),
    .head_o (head),
    .count_o(count)
  );

  adc_fifo_status #(.DEPTH(DEPTH)) u_status (
    .clk_i, .rst_ni, .clr_i,
    .push_i    (push),
    .pop_i     (pop),
    .drop_i    (drop),
    .count_i   (count),
    .thresh_i,
    .ovf_clr_i,
    .irq_clr_i,
    .ovf_o,
    .irq_flag_o
  );

  adc_fifo_rdport u_rdport (
    .clk_i, .rst_ni,
    .strobe_i(rd_lo_i || rd_hi_i),
    .valid_i (!empty_o),
    .layout_i,
    .head_i  (head),
    .data_o  (rd_data_o)
  );

  assign irq_o = irq_flag_o && irq_en_i;

  // R4
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_valid_i && !rd_hi_i && !clr_i) |=> full_o);

  // R2
  first_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && wr_valid_i && !clr_i) |=> !empty_o);

  // R8
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && rd_hi_i && !wr_valid_i) |=> empty_o);

  // R5
  clear_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !full_o && !ovf_o));
endmodule

// File: tb/adc_result_fifo_bench.sv
module adc_result_fifo_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 0, wr_tag = 0, rd_lo = 0, rd_hi = 0;
  logic        clr = 0, ovf_clr = 0, irq_clr = 0, irq_en = 0, layout = 0;
  logic [9:0]  wr_result = '0;
  logic [4:0]  wr_chan = '0;
  logic [1:0]  thresh = '0;
  logic [15:0] rd_data;
  logic        empty, full, ovf, irq_flag, irq;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  adc_result_fifo u_adc_result_fifo (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_valid_i(wr_valid), .wr_result_i(wr_result), .wr_tag_i(wr_tag), .wr_chan_i(wr_chan),
    .rd_lo_i(rd_lo), .rd_hi_i(rd_hi), .clr_i(clr), .ovf_clr_i(ovf_clr), .irq_clr_i(irq_clr),
    .thresh_i(thresh), .irq_en_i(irq_en), .layout_i(layout),
    .rd_data_o(rd_data), .empty_o(empty), .full_o(full), .ovf_o(ovf),
    .irq_flag_o(irq_flag), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] r, input logic t, input logic [4:0] c);
    @(negedge clk);
    wr_valid = 1; wr_result = r; wr_tag = t; wr_chan = c;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic lo, input logic hi);
    @(negedge clk);
    rd_lo = lo; rd_hi = hi;
    @(negedge clk);
    rd_lo = 0; rd_hi = 0;
  endtask

  task automatic pulse_irq_clr();
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty", 16'(empty), 16'd1);
    chk("R1 full", 16'(full), 16'd0);
    chk("R1 ovf", 16'(ovf), 16'd0);
    chk("R1 irq_flag", 16'(irq_flag), 16'd0);
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 data", rd_data, 16'h0000);
  endtask

  task automatic t_first_entry();
    thresh = 2'd0; irq_en = 1;
    push(10'h155, 1'b1, 5'd3);
    chk("R2 empty cleared", 16'(empty), 16'd0);
    chk("R6 flag at N=0", 16'(irq_flag), 16'd1);
    chk("R7 irq enabled", 16'(irq), 16'd1);
    irq_en = 0; #1;
    chk("R7 irq masked", 16'(irq), 16'd0);
    pulse_irq_clr();
    chk("R11 irq flag cleared", 16'(irq_flag), 16'd0);
    rd(1, 1);
    chk("R9 packed word", rd_data, 16'h5563);
    chk("R13 pop empties", 16'(empty), 16'd1);
  endtask

  task automatic t_fill_overflow();
    thresh = 2'd3;
    push(10'h3FF, 1'b0, 5'd0);
    push(10'h001, 1'b1, 5'd31);
    push(10'h200, 1'b0, 5'd16);
    chk("R3 not full at 3", 16'(full), 16'd0);
    chk("R6 no flag at 3 (N=3)", 16'(irq_flag), 16'd0);
    push(10'h0AA, 1'b1, 5'd1);
    chk("R3 full at 4", 16'(full), 16'd1);
    chk("R6 flag at 4 (N=3)", 16'(irq_flag), 16'd1);
    chk("R4 no ovf yet", 16'(ovf), 16'd0);
    push(10'h111, 1'b0, 5'd7);
    chk("R4 ovf set", 16'(ovf), 16'd1);
    chk("R4 still full", 16'(full), 16'd1);
    @(negedge clk);
    chk("R11 ovf sticky", 16'(ovf), 16'd1);
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk("R11 ovf cleared", 16'(ovf), 16'd0);
    pulse_irq_clr();
    rd(1, 0);
    chk("R8 low byte read", rd_data, 16'hFFC0);
    chk("R8 low byte no pop", 16'(full), 16'd1);
    rd(1, 0);
    chk("R8 low byte repeat", rd_data, 16'hFFC0);
    rd(0, 1);
    chk("R8 high byte read", rd_data, 16'hFFC0);
    chk("R8 high byte pops", 16'(full), 16'd0);
    rd(1, 1);
    chk("R3 order 2", rd_data, 16'h007F);
    rd(1, 1);
    chk("R3 order 3", rd_data, 16'h8010);
    rd(1, 1);
    chk("R4 last kept, not overwritten", rd_data, 16'h2AA1);
    chk("R3 empty after 4", 16'(empty), 16'd1);
  endtask

  task automatic t_layout();
    layout = 1;
    push(10'h2D5, 1'b1, 5'd9);
    rd(1, 1);
    chk("R10 right justified", rd_data, 16'h02D5);
    layout = 0;
  endtask

  task automatic t_thresh_and_clear();
    thresh = 2'd2;
    push(10'h010, 1'b0, 5'd1);
    chk("R6 no flag at 1 (N=2)", 16'(irq_flag), 16'd0);
    push(10'h020, 1'b0, 5'd2);
    chk("R6 no flag at 2 (N=2)", 16'(irq_flag), 16'd0);
    push(10'h030, 1'b0, 5'd3);
    chk("R6 flag at 3 (N=2)", 16'(irq_flag), 16'd1);
    push(10'h040, 1'b0, 5'd4);
    push(10'h050, 1'b0, 5'd5);
    chk("R4 ovf before clear", 16'(ovf), 16'd1);
    @(negedge clk); clr = 1; wr_valid = 1; wr_result = 10'h3AB;
    @(negedge clk); clr = 0; wr_valid = 0;
    chk("R5 empty after clear", 16'(empty), 16'd1);
    chk("R5 not full after clear", 16'(full), 16'd0);
    chk("R11 clear drops ovf", 16'(ovf), 16'd0);
    chk("R11 irq flag kept over clear", 16'(irq_flag), 16'd1);
    pulse_irq_clr();
  endtask

  task automatic t_empty_and_concurrent();
    rd(1, 1);
    chk("R12 empty read holds data", rd_data, 16'h02D5);
    chk("R12 empty read stays empty", 16'(empty), 16'd1);
    push(10'h0F0, 1'b0, 5'd2);
    @(negedge clk);
    wr_valid = 1; wr_result = 10'h033; wr_tag = 1; wr_chan = 5'd4;
    rd_lo = 1; rd_hi = 1;
    @(negedge clk);
    wr_valid = 0; rd_lo = 0; rd_hi = 0;
    chk("R12 concurrent pop data", rd_data, 16'h3C02);
    chk("R12 concurrent write kept", 16'(empty), 16'd0);
    rd(1, 1);
    chk("R12 concurrent write data", rd_data, 16'h0CE4);
    chk("R12 drained", 16'(empty), 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first_entry();
    t_fill_overflow();
    t_layout();
    t_thresh_and_clear();
    t_empty_and_concurrent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule